// File: doc/BRIEF.md
# ADC Conversion Start Controller

This block decides when an eight-input analog-to-digital converter core converts, on which input, and when a conversion has to be thrown away. Software writes a small mode register and a channel register. The block samples an external trigger pin and exchanges start, abort and done handshakes with the converter core. It keeps the last good result in a register that software can read, and it raises a one-cycle completion interrupt.

There are two ways to start. In free-running mode, writing the mode register with the enable bit set and the hardware bit clear starts a conversion at once. After that, conversions follow each other with no gap. In triggered mode the block waits in standby. Each qualified edge on the trigger pin then gives exactly one conversion. A channel write in the middle of a conversion aborts it. In triggered mode the block then goes back to standby. In free-running mode it starts again at once on the new input. Clearing the enable bit aborts the conversion and stops the block.

Top module: `adc_conv_ctrl`

## Requirements
- R1: After reset, `mux_sel`, `conv_start`, `conv_abort`, `done_irq` and `result_q` are all zero, and no conversion starts until the mode register is written.
- R2: A mode write whose bit 0 (enable) is 1 and bit 1 (hardware trigger) is 0 makes `conv_start` high for one cycle, in the cycle after the write. `mux_sel` then shows the channel register. `conv_start` is only ever high while the enable bit is set.
- R3: In free-running mode, the cycle that shows `done_irq` also shows the `conv_start` of the next conversion.
- R4: A mode write with bits 1:0 = 11 puts the block in standby. It starts nothing until a qualified trigger edge has been detected.
- R5: Mode bits 3:2 select the qualified edge: 00 = falling, 01 = rising, 1x = both. The trigger pin passes through a two-stage synchroniser before the edge is detected.
- R6: When the core reports done during a live conversion, `result_q` takes `core_result`, and `done_irq` is high for that same single cycle. `result_q` changes at no other time.
- R7: In triggered mode, once a conversion completes, no further conversion starts until a new qualified edge arrives.
- R8: In triggered mode, a channel write during a conversion raises `conv_abort` for one cycle. It produces no interrupt and leaves `result_q` unchanged, and the block returns to standby. The next edge converts the new channel.
- R9: A channel write during standby is used by the conversion that the next edge starts.
- R10: A mode write with the enable bit 0 during a conversion raises `conv_abort` in the next cycle, with no start and no interrupt. No conversion follows.
- R11: In free-running mode, a channel write during a conversion raises `conv_abort` and `conv_start` in the same cycle, with `mux_sel` already on the new channel.
- R12: In triggered mode, trigger edges that arrive while a conversion is running are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode data: [0] enable, [1] hardware trigger, [3:2] edge select |
| chan_wr | input | 1 | Channel register write strobe |
| chan_wdata | input | CH_W | Channel to convert |
| trig_pin | input | 1 | Asynchronous external trigger |
| core_done | input | 1 | Core finished the current conversion |
| core_result | input | RES_W | Core conversion value |
| mux_sel | output | CH_W | Analog input select to the core |
| conv_start | output | 1 | One-cycle start strobe to the core |
| conv_abort | output | 1 | One-cycle abort strobe to the core |
| result_q | output | RES_W | Last completed result |
| done_irq | output | 1 | One-cycle completion interrupt |

## Verification
The cycle-level rules are checked by assertions on every cycle:
- a start needs the enable bit;
- standby without a qualified edge never starts a conversion;
- clearing the enable bit during a conversion aborts it;
- the result register changes only together with the interrupt;
- an abort never comes with an interrupt;
- a triggered completion falls back to standby.

Other behaviour shows only across a whole scenario, so the bench covers it:
- the sweep of all four edge-select codes in both pin directions;
- back-to-back free-running conversions;
- the channel an aborted-then-retriggered conversion finally reports;
- edges that arrive in the middle of a conversion being ignored.

// File: rtl/adc_conv_pkg.sv
package adc_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_STANDBY = 2'd1,
    ST_CONV    = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [1:0] edge_sel;
    logic       hw_trig;
    logic       enable;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

endpackage

// File: rtl/adc_trig_detect.sv
module adc_trig_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_pin,
  input  logic [1:0] edge_sel,
  output logic       trig_valid
);

  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_n;
  logic               now_lvl;
  logic               old_lvl;
  logic               rise;
  logic               fall;

  always_comb begin
    chain_n = {chain_q[CHAIN_W-2:0], trig_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_n;
    end
  end

  assign now_lvl = chain_q[SYNC_STAGES-1];
  assign old_lvl = chain_q[SYNC_STAGES];
  assign rise    = now_lvl & ~old_lvl;
  assign fall    = ~now_lvl & old_lvl;

  always_comb begin
    if (edge_sel[1]) begin
      trig_valid = rise | fall;
    end else if (edge_sel[0]) begin
      trig_valid = rise;
    end else begin
      trig_valid = fall;
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_conv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  mode_t      mode_q,
  input  logic       mode_wr,
  input  mode_t      mode_wd,
  input  logic       chan_wr,
  input  logic       trig_valid,
  input  logic       core_done,
  output seq_state_e state_q,
  output logic       start_q,
  output logic       abort_q,
  output logic       capture
);

  seq_state_e state_n;
  logic       start_n;
  logic       abort_n;

  always_comb begin
    state_n = state_q;
    start_n = 1'b0;
    abort_n = 1'b0;
    capture = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (mode_wr && mode_wd.enable) begin
          if (mode_wd.hw_trig) begin
            state_n = ST_STANDBY;
          end else begin
            state_n = ST_CONV;
            start_n = 1'b1;
          end
        end
      end
      ST_STANDBY: begin
        if (mode_wr) begin
          if (!mode_wd.enable) begin
            state_n = ST_IDLE;
          end else if (!mode_wd.hw_trig) begin
            state_n = ST_CONV;
            start_n = 1'b1;
          end
        end else if (trig_valid) begin
          state_n = ST_CONV;
          start_n = 1'b1;
        end
      end
      ST_CONV: begin
        if (mode_wr) begin
          abort_n = 1'b1;
          if (!mode_wd.enable) begin
            state_n = ST_IDLE;
          end else if (mode_wd.hw_trig) begin
            state_n = ST_STANDBY;
          end else begin
            start_n = 1'b1;
          end
        end else if (chan_wr) begin
          abort_n = 1'b1;
          if (mode_q.hw_trig) begin
            state_n = ST_STANDBY;
          end else begin
            start_n = 1'b1;
          end
        end else if (core_done) begin
          capture = 1'b1;
          if (mode_q.hw_trig) begin
            state_n = ST_STANDBY;
          end else begin
            start_n = 1'b1;
          end
        end
      end
      default: begin
        state_n = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_n;
      start_q <= start_n;
      abort_q <= abort_n;
    end
  end

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [RES_W-1:0] core_result,
  output logic [RES_W-1:0] result_q,
  output logic             irq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (capture) begin
      result_q <= core_result;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= capture;
    end
  end

endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_conv_pkg::*;
#(
  parameter int CH_W        = 3,
  parameter int RES_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic [3:0]       mode_wdata,
  input  logic             chan_wr,
  input  logic [CH_W-1:0]  chan_wdata,
  input  logic             trig_pin,
  input  logic             core_done,
  input  logic [RES_W-1:0] core_result,
  output logic [CH_W-1:0]  mux_sel,
  output logic             conv_start,
  output logic             conv_abort,
  output logic [RES_W-1:0] result_q,
  output logic             done_irq
);

  mode_t      mode_q;
  mode_t      mode_wd;
  logic [CH_W-1:0] chan_q;
  logic       trig_valid;
  logic       capture;
  seq_state_e seq_state;

  assign mode_wd = mode_t'(mode_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (mode_wr) begin
      mode_q <= mode_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
    end else if (chan_wr) begin
      chan_q <= chan_wdata;
    end
  end

  assign mux_sel = chan_q;

  adc_trig_detect #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_pin  (trig_pin),
    .edge_sel  (mode_q.edge_sel),
    .trig_valid(trig_valid)
  );

  adc_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .mode_wr   (mode_wr),
    .mode_wd   (mode_wd),
    .chan_wr   (chan_wr),
    .trig_valid(trig_valid),
    .core_done (core_done),
    .state_q   (seq_state),
    .start_q   (conv_start),
    .abort_q   (conv_abort),
    .capture   (capture)
  );

  adc_result_reg #(
    .RES_W(RES_W)
  ) u_res (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (capture),
    .core_result(core_result),
    .result_q   (result_q),
    .irq_q      (done_irq)
  );

endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [3:0]       mode_wdata,
  input logic             chan_wr,
  input logic             core_done,
  input logic [3:0]       mode_bits,
  input logic [1:0]       state_bits,
  input logic             trig_valid,
  input logic             conv_start,
  input logic             conv_abort,
  input logic [RES_W-1:0] result_q,
  input logic             done_irq
);

  localparam logic [1:0] S_STANDBY = 2'd1;
  localparam logic [1:0] S_CONV    = 2'd2;

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> mode_bits[0]); // R2

  AST_STANDBY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == S_STANDBY && !mode_wr && !trig_valid) |=> !conv_start); // R4

  AST_RESULT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_q) |-> done_irq); // R6

  AST_HW_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == S_CONV && core_done && mode_bits[1] && !mode_wr && !chan_wr)
      |=> (!conv_start && state_bits == S_STANDBY)); // R7

  AST_ABORT_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |-> !done_irq); // R8

  AST_DISABLE_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_bits == S_CONV && mode_wr && !mode_wdata[0])
      |=> (conv_abort && !conv_start && !done_irq)); // R10

endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
  .CH_W (CH_W),
  .RES_W(RES_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_wr   (mode_wr),
  .mode_wdata(mode_wdata),
  .chan_wr   (chan_wr),
  .core_done (core_done),
  .mode_bits (mode_q),
  .state_bits(seq_state),
  .trig_valid(trig_valid),
  .conv_start(conv_start),
  .conv_abort(conv_abort),
  .result_q  (result_q),
  .done_irq  (done_irq)
);

// File: tb/adc_conv_ctrl_tb.sv
`timescale 1ns/1ps
module adc_conv_ctrl_tb;

  localparam int CH_W  = 3;
  localparam int RES_W = 10;
  localparam int LAT   = 8;

  logic             clk;
  logic             rst_n;
  logic             mode_wr;
  logic [3:0]       mode_wdata;
  logic             chan_wr;
  logic [CH_W-1:0]  chan_wdata;
  logic             trig_pin;
  logic             core_done;
  logic [RES_W-1:0] core_result;
  logic [CH_W-1:0]  mux_sel;
  logic             conv_start;
  logic             conv_abort;
  logic [RES_W-1:0] result_q;
  logic             done_irq;

  int n_cmp;
  int n_bad;
  int n_start;
  int n_abort;
  int n_irq;

  adc_conv_ctrl #(.CH_W(CH_W), .RES_W(RES_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .chan_wr(chan_wr), .chan_wdata(chan_wdata), .trig_pin(trig_pin),
    .core_done(core_done), .core_result(core_result), .mux_sel(mux_sel),
    .conv_start(conv_start), .conv_abort(conv_abort), .result_q(result_q),
    .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Converter core model: fixed latency, result = {channel, sequence}
  logic            busy;
  int              cnt;
  logic [CH_W-1:0] core_ch;
  logic [6:0]      seq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= 0; core_ch <= '0; seq <= '0;
      core_done <= 1'b0; core_result <= '0;
    end else begin
      core_done <= 1'b0;
      if (conv_start) begin
        busy <= 1'b1; cnt <= LAT; core_ch <= mux_sel;
      end else if (conv_abort) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (cnt == 1) begin
          core_done   <= 1'b1;
          core_result <= {core_ch, seq};
          seq         <= seq + 7'd1;
          busy        <= 1'b0;
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pulse monitor and result tracking
  logic [RES_W-1:0] prev_res;
  always @(posedge clk) begin
    if (rst_n) begin
      if (conv_start) n_start++;
      if (conv_abort) n_abort++;
      if (done_irq) begin
        n_irq++;
        chk(result_q == core_result, "R6 result", int'(result_q), int'(core_result));
      end
      if (result_q != prev_res && !done_irq)
        chk(1'b0, "R6 result moved without irq", int'(result_q), int'(prev_res));
      prev_res <= result_q;
    end else begin
      prev_res <= '0;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic [3:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic wr_chan(input logic [CH_W-1:0] c);
    @(negedge clk); chan_wr = 1'b1; chan_wdata = c;
    @(negedge clk); chan_wr = 1'b0;
  endtask

  task automatic wait_start(input string tag);
    int k;
    k = 0;
    while (!conv_start && k < 40) begin @(negedge clk); k++; end
    chk(conv_start, tag, int'(conv_start), 1);
  endtask

  task automatic wait_irq(input string tag);
    int k;
    k = 0;
    while (!done_irq && k < 60) begin @(negedge clk); k++; end
    chk(done_irq, tag, int'(done_irq), 1);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int s0;
    int i0;
    int a0;
    logic [RES_W-1:0] r0;
    n_cmp = 0; n_bad = 0; n_start = 0; n_abort = 0; n_irq = 0;
    rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = '0; chan_wr = 1'b0;
    chan_wdata = '0; trig_pin = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(10);
    // R1: reset state, nothing starts on its own
    chk(mux_sel == 0 && !conv_start && !conv_abort && !done_irq, "R1 outputs",
        int'({mux_sel, conv_start, conv_abort, done_irq}), 0);
    chk(result_q == 0, "R1 result", int'(result_q), 0);
    chk(n_start == 0, "R1 no start", n_start, 0);

    // R2/R3: free-running on channel 3
    wr_chan(3'd3);
    wr_mode(4'b0001);
    chk(conv_start == 1'b1, "R2 start after mode write", int'(conv_start), 1);
    chk(mux_sel == 3, "R2 mux select", int'(mux_sel), 3);
    for (int k = 0; k < 3; k++) begin
      wait_irq("R3 completion");
      chk(conv_start == 1'b1, "R3 back-to-back start", int'(conv_start), 1);
      chk(result_q[9:7] == 3, "R6 channel in result", int'(result_q[9:7]), 3);
      tick(1);
    end

    // R11: channel change restarts at once
    wait_start("R11 running");
    tick(2);
    i0 = n_irq;
    wr_chan(3'd5);
    chk(conv_abort && conv_start, "R11 abort+start same cycle",
        int'({conv_abort, conv_start}), 3);
    chk(mux_sel == 5, "R11 new channel", int'(mux_sel), 5);
    wait_irq("R11 completion");
    chk(result_q[9:7] == 5, "R11 result channel", int'(result_q[9:7]), 5);
    chk(n_irq == i0, "R11 aborted gave no irq", n_irq, i0);

    // R10: clearing enable aborts and stops
    wait_start("R10 running");
    tick(2);
    wr_mode(4'b0000);
    chk(conv_abort && !conv_start, "R10 abort no start",
        int'({conv_abort, conv_start}), 2);
    s0 = n_start; i0 = n_irq; r0 = result_q;
    tick(30);
    chk(n_start == s0 + 0, "R10 no restart", n_start, s0);
    chk(n_irq == i0, "R10 no irq", n_irq, i0);
    chk(result_q == r0, "R10 result kept", int'(result_q), int'(r0));

    // R4/R5/R7: sweep every edge code in both directions
    for (int code = 0; code < 4; code++) begin
      wr_mode(4'((code << 2) | 3));
      s0 = n_start;
      tick(10);
      chk(n_start == s0, "R4 standby idle", n_start, s0);
      for (int dir = 0; dir < 2; dir++) begin
        int exp_n;
        exp_n = (code >= 2) ? 1 : ((code == 1) ? (dir == 0 ? 1 : 0) : (dir == 1 ? 1 : 0));
        s0 = n_start; i0 = n_irq;
        trig_pin = ~trig_pin;
        tick(LAT + 12);
        chk(n_start - s0 == exp_n, $sformatf("R5 edge code %0d dir %0d", code, dir),
            n_start - s0, exp_n);
        chk(n_irq - i0 == exp_n, "R5 completion count", n_irq - i0, exp_n);
        tick(20);
        chk(n_start - s0 == exp_n, "R7 single conversion per edge", n_start - s0, exp_n);
      end
    end

    // R12: edges inside a conversion are ignored (both-edge mode)
    wr_mode(4'b1011);
    s0 = n_start; i0 = n_irq;
    trig_pin = ~trig_pin;
    wait_start("R12 start");
    tick(1); trig_pin = ~trig_pin;
    tick(1); trig_pin = ~trig_pin;
    tick(LAT + 15);
    chk(n_start - s0 == 1, "R12 one start", n_start - s0, 1);
    chk(n_irq - i0 == 1, "R12 one irq", n_irq - i0, 1);

    // R8: channel write aborts a triggered conversion
    wr_chan(3'd2);
    trig_pin = ~trig_pin;
    wait_start("R8 start");
    chk(mux_sel == 2, "R9 channel from standby write", int'(mux_sel), 2);
    tick(2);
    a0 = n_abort;
    wr_chan(3'd6);
    chk(conv_abort && !conv_start, "R8 abort without restart",
        int'({conv_abort, conv_start}), 2);
    s0 = n_start; i0 = n_irq; r0 = result_q;
    tick(LAT + 10);
    chk(n_abort - a0 == 1, "R8 single abort", n_abort - a0, 1);
    chk(n_start == s0 && n_irq == i0, "R8 stays in standby", n_start - s0 + n_irq - i0, 0);
    chk(result_q == r0, "R8 result kept", int'(result_q), int'(r0));
    trig_pin = ~trig_pin;
    wait_start("R8 retrigger");
    chk(mux_sel == 6, "R8 new channel", int'(mux_sel), 6);
    wait_irq("R8 completion");
    chk(result_q[9:7] == 6, "R8 result channel", int'(result_q[9:7]), 6);

    // R9: standby channel write used at next edge
    tick(3);
    wr_chan(3'd1);
    tick(2);
    trig_pin = ~trig_pin;
    wait_irq("R9 completion");
    chk(result_q[9:7] == 1, "R9 result channel", int'(result_q[9:7]), 1);

    tick(5);
    summary();
    $finish;
  end

endmodule